// File: doc/BRIEF.md
# Multi-Lane Byte Merger

This block sits between a set of serial-link receiver lanes and the packet layer. Each lane hands over one byte per byte-clock cycle, along with a valid flag and a start-of-transmission flag. The block merges those bytes into a single stream of 32-bit words, in the order the transmitter spread them across the lanes. A configuration input selects how many lanes are in use, from one up to the full count. Lanes above that count are ignored. The output word is always 32 bits wide, whatever the lane count.

At the start of a burst the block checks that every active lane has begun within a short skew window. If they have, it delays the earlier lanes so that all lanes line up. If one lane is late or missing, it flags a lane-sync error and discards the whole burst. Bytes are packed into words through a carry register, so a three-lane burst spills bytes across word boundaries. When lane 0 stops delivering, the block closes the burst with a terminator word. That word carries the leftover bytes and a byte-enable mask.

Separately, the block watches the low-power state of the active lanes. It reports entry into that state as a level and as a one-cycle pulse. The lane-count setting is taken in only when the aligner is idle and no active lane carries data.

Top module: `lane_merge_top`

## Requirements
- R1: A `cfg_lanes` value v makes lanes 0..v active (v+1 lanes). A byte count of N lanes means byte n of a burst travels on lane n mod N.
- R2: Output byte k of a word occupies bits [8k+7:8k]. Bytes appear in burst order. Every word that is not a terminator has `out_be` = 4'b1111 and `out_last` = 0.
- R3: With one, two, three or four active lanes, the output is 32-bit words. For three lanes, bytes left over from one cycle are carried into the next word.
- R4: A lane's first byte is marked by `lane_sot` together with `lane_vld`. Each active lane may begin up to SKEW (default 2) cycles after the first active lane, and the merged words do not depend on that skew.
- R5: If some active lane has not shown its start flag within SKEW cycles after the first one, `lane_err` pulses for one cycle. No word of that burst is emitted.
- R6: When a burst ends, exactly one terminator word follows, with `out_last` = 1. It holds the r leftover bytes (r = 0..3) in bytes 0..r-1, with `out_be` bits 0..r-1 set and all other bits and bytes zero. When r = 0, `out_be` = 0.
- R7: Byte, valid, start and low-power inputs of lanes at or above the active count have no effect on any output.
- R8: A new `cfg_lanes` value is taken in only while the aligner is idle and no active lane asserts valid. A change made during a burst applies only to later bursts.
- R9: `lp_idle` is high one cycle after all active lanes assert `lane_lp`. `lp_entry` pulses for one cycle on that entry.
- R10: After reset, `out_vld`, `lane_err` and `lp_entry` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_lanes | input | CFG_W (2) | Active lane count minus one |
| lane_byte | input | LANES*8 (32) | Byte of each lane, lane i at bits [8i+7:8i] |
| lane_vld | input | LANES (4) | Byte valid per lane |
| lane_sot | input | LANES (4) | Start of transmission per lane, with first byte |
| lane_lp | input | LANES (4) | Lane is in low-power state |
| out_vld | output | 1 | Output word valid |
| out_data | output | 32 | Merged word, byte k at bits [8k+7:8k] |
| out_be | output | 4 | Byte enables of the word |
| out_last | output | 1 | Terminator word of a burst |
| lane_err | output | 1 | Lane-sync error pulse |
| lp_idle | output | 1 | All active lanes in low-power state |
| lp_entry | output | 1 | Pulse on entry into low-power state |

## Verification
The bench builds the block with four lanes and a skew window of two cycles. Because the lane count is set at run time, these defaults give every lane count from one to four, including the three-lane carry path. They also give every skew offset from zero to the window edge, and one step past it for the sync-error case. Burst lengths are chosen so that the terminator holds zero, one, two and three leftover bytes.

// File: rtl/lane_merge_pkg.sv
package lane_merge_pkg;

    localparam int WORD_BYTES = 4;
    localparam int WORD_W     = 8 * WORD_BYTES;

    // one byte slot of a lane after capture
    typedef struct packed {
        logic       vld;
        logic [7:0] data;
    } lane_beat_t;

    typedef enum logic [1:0] {
        AL_IDLE,
        AL_WAIT,
        AL_RUN,
        AL_DROP
    } align_state_e;

    typedef struct packed {
        logic [WORD_W-1:0]     data;
        logic [WORD_BYTES-1:0] be;
        logic                  last;
    } word_t;

    // mask with the lowest n bits set
    function automatic logic [WORD_BYTES-1:0] low_mask(input int n);
        logic [WORD_BYTES-1:0] m;
        m = '0;
        for (int i = 0; i < WORD_BYTES; i++) begin
            if (i < n) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/lane_align.sv
module lane_align
    import lane_merge_pkg::*;
#(
    parameter int LANES = 4,
    parameter int SKEW  = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [LANES-1:0]   act,
    input  logic [LANES*8-1:0] lane_byte,
    input  logic [LANES-1:0]   lane_vld,
    input  logic [LANES-1:0]   lane_sot,
    output logic               beat_vld,
    output logic               beat_end,
    output logic [LANES-1:0]   beat_mask,
    output logic [LANES*8-1:0] beat_byte,
    output logic               sync_err,
    output logic               idle
);

    localparam int OFF_W = (SKEW > 0) ? $clog2(SKEW + 1) : 1;

    align_state_e           state_q;
    logic [LANES-1:0]       seen_q;
    logic [OFF_W-1:0]       win_q;
    logic [OFF_W-1:0]       off_q [LANES];
    logic                   got_q;
    logic                   err_q;
    lane_beat_t             dly   [LANES][SKEW+1];
    lane_beat_t             tap   [LANES];
    logic [LANES-1:0]       tap_vld;
    logic [LANES-1:0]       sot_act;
    logic [LANES-1:0]       seen_nx;
    logic [OFF_W:0]         elapsed;

    // per-lane deskew delay lines and tap selection
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                for (int d = 0; d <= SKEW; d++) dly[i][d] <= '0;
            end else begin
                dly[i][0] <= '{vld: lane_vld[i], data: lane_byte[8*i +: 8]};
                for (int d = 1; d <= SKEW; d++) dly[i][d] <= dly[i][d-1];
            end
        end

        always_comb begin
            tap[i] = '0;
            for (int d = 0; d <= SKEW; d++) begin
                if (int'(off_q[i]) == SKEW - d) tap[i] = dly[i][d];
            end
        end

        assign tap_vld[i]           = tap[i].vld;
        assign beat_mask[i]         = tap[i].vld & act[i];
        assign beat_byte[8*i +: 8]  = tap[i].data;
    end

    assign sot_act  = lane_sot & lane_vld & act;
    assign seen_nx  = seen_q | sot_act;
    assign elapsed  = {1'b0, win_q} + 1'b1;

    assign beat_vld = (state_q == AL_RUN) && tap_vld[0];
    assign beat_end = (state_q == AL_RUN) && got_q && !tap_vld[0];
    assign sync_err = err_q;
    assign idle     = (state_q == AL_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= AL_IDLE;
            seen_q  <= '0;
            win_q   <= '0;
            got_q   <= 1'b0;
            err_q   <= 1'b0;
            for (int i = 0; i < LANES; i++) off_q[i] <= '0;
        end else begin
            err_q <= 1'b0;
            case (state_q)
                AL_IDLE: begin
                    if (|sot_act) begin
                        seen_q <= sot_act;
                        win_q  <= '0;
                        got_q  <= 1'b0;
                        for (int i = 0; i < LANES; i++) off_q[i] <= '0;
                        state_q <= (sot_act == act) ? AL_RUN : AL_WAIT;
                    end
                end
                AL_WAIT: begin
                    seen_q <= seen_nx;
                    win_q  <= OFF_W'(elapsed);
                    for (int i = 0; i < LANES; i++) begin
                        if (sot_act[i] && !seen_q[i]) off_q[i] <= OFF_W'(elapsed);
                    end
                    if (seen_nx == act) begin
                        state_q <= AL_RUN;
                    end else if (int'(elapsed) >= SKEW) begin
                        err_q   <= 1'b1;
                        state_q <= AL_DROP;
                    end
                end
                AL_RUN: begin
                    if (beat_vld) got_q <= 1'b1;
                    if (beat_end) state_q <= AL_IDLE;
                end
                default: begin
                    if (!(|(lane_vld & act))) state_q <= AL_IDLE;
                end
            endcase
        end
    end

    // R5
    drop_after_err_chk: assert property (@(posedge clk) disable iff (rst)
        err_q |-> (state_q == AL_DROP));

    // R4
    run_all_seen_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == AL_RUN) |-> (seen_q == act));

endmodule

// File: rtl/lane_pack.sv
module lane_pack
    import lane_merge_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               beat_vld,
    input  logic               beat_end,
    input  logic [LANES-1:0]   beat_mask,
    input  logic [LANES*8-1:0] beat_byte,
    output word_t              word,
    output logic               word_vld
);

    localparam int CARRY_N = WORD_BYTES - 1;
    localparam int ACC_N   = WORD_BYTES + LANES - 1;
    localparam int FILL_W  = $clog2(WORD_BYTES);

    logic [7:0]        acc_q [CARRY_N];
    logic [FILL_W-1:0] fill_q;
    logic [7:0]        tmp   [ACC_N];
    int                cnt;
    int                total;
    word_t             word_q;
    logic              word_vld_q;

    always_comb begin
        cnt   = $countones(beat_mask);
        total = int'(fill_q) + cnt;
        for (int j = 0; j < ACC_N; j++) begin
            tmp[j] = '0;
            if (j < CARRY_N && j < int'(fill_q)) tmp[j] = acc_q[j];
            for (int l = 0; l < LANES; l++) begin
                if (l < cnt && j == int'(fill_q) + l) tmp[j] = beat_byte[8*l +: 8];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_vld_q <= 1'b0;
            word_q     <= '0;
            fill_q     <= '0;
            for (int m = 0; m < CARRY_N; m++) acc_q[m] <= '0;
        end else begin
            word_vld_q <= 1'b0;
            if (beat_vld) begin
                if (total >= WORD_BYTES) begin
                    word_vld_q  <= 1'b1;
                    word_q.be   <= '1;
                    word_q.last <= 1'b0;
                    for (int m = 0; m < WORD_BYTES; m++) word_q.data[8*m +: 8] <= tmp[m];
                    for (int m = 0; m < CARRY_N; m++) begin
                        if (m + WORD_BYTES < ACC_N) acc_q[m] <= tmp[m + WORD_BYTES];
                        else acc_q[m] <= '0;
                    end
                    fill_q <= FILL_W'(total - WORD_BYTES);
                end else begin
                    for (int m = 0; m < CARRY_N; m++) acc_q[m] <= tmp[m];
                    fill_q <= FILL_W'(total);
                end
            end else if (beat_end) begin
                word_vld_q  <= 1'b1;
                word_q.be   <= low_mask(int'(fill_q));
                word_q.last <= 1'b1;
                for (int m = 0; m < WORD_BYTES; m++) begin
                    if (m < CARRY_N && m < int'(fill_q)) word_q.data[8*m +: 8] <= acc_q[m];
                    else word_q.data[8*m +: 8] <= '0;
                end
                fill_q <= '0;
            end
        end
    end

    assign word     = word_q;
    assign word_vld = word_vld_q;

    // R6
    be_prefix_chk: assert property (@(posedge clk) disable iff (rst)
        word_vld_q |-> ((WORD_BYTES'(word_q.be + 1'b1) & word_q.be) == '0));

    // R6
    last_after_end_chk: assert property (@(posedge clk) disable iff (rst)
        (word_vld_q && word_q.last) |-> $past(beat_end));

    // R2
    full_word_chk: assert property (@(posedge clk) disable iff (rst)
        (word_vld_q && !word_q.last) |-> (word_q.be == '1));

endmodule

// File: rtl/lane_lp_watch.sv
module lane_lp_watch #(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LANES-1:0] act,
    input  logic [LANES-1:0] lane_lp,
    output logic             lp_idle,
    output logic             lp_entry
);

    logic all_lp;
    logic idle_q;
    logic entry_q;

    assign all_lp = &(lane_lp | ~act);

    always_ff @(posedge clk) begin
        if (rst) begin
            idle_q  <= 1'b0;
            entry_q <= 1'b0;
        end else begin
            idle_q  <= all_lp;
            entry_q <= all_lp & ~idle_q;
        end
    end

    assign lp_idle  = idle_q;
    assign lp_entry = entry_q;

    // R9
    entry_implies_idle_chk: assert property (@(posedge clk) disable iff (rst)
        entry_q |-> idle_q);

    // R9
    entry_single_chk: assert property (@(posedge clk) disable iff (rst)
        entry_q |=> !entry_q);

endmodule

// File: rtl/lane_merge_top.sv
module lane_merge_top
    import lane_merge_pkg::*;
#(
    parameter int LANES = 4,
    parameter int SKEW  = 2,
    localparam int CFG_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [CFG_W-1:0]   cfg_lanes,
    input  logic [LANES*8-1:0] lane_byte,
    input  logic [LANES-1:0]   lane_vld,
    input  logic [LANES-1:0]   lane_sot,
    input  logic [LANES-1:0]   lane_lp,
    output logic               out_vld,
    output logic [WORD_W-1:0]  out_data,
    output logic [WORD_BYTES-1:0] out_be,
    output logic               out_last,
    output logic               lane_err,
    output logic               lp_idle,
    output logic               lp_entry
);

    logic [CFG_W-1:0]   act_q;
    logic [LANES-1:0]   act;
    logic               align_idle;
    logic               beat_vld;
    logic               beat_end;
    logic [LANES-1:0]   beat_mask;
    logic [LANES*8-1:0] beat_byte;
    word_t              word;

    always_comb begin
        for (int i = 0; i < LANES; i++) act[i] = (i <= int'(act_q));
    end

    // lane count is latched only between bursts
    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= CFG_W'(LANES - 1);
        end else if (align_idle && !(|(lane_vld & act))) begin
            act_q <= cfg_lanes;
        end
    end

    lane_align #(.LANES(LANES), .SKEW(SKEW)) align_i (
        .clk       (clk),
        .rst       (rst),
        .act       (act),
        .lane_byte (lane_byte),
        .lane_vld  (lane_vld),
        .lane_sot  (lane_sot),
        .beat_vld  (beat_vld),
        .beat_end  (beat_end),
        .beat_mask (beat_mask),
        .beat_byte (beat_byte),
        .sync_err  (lane_err),
        .idle      (align_idle)
    );

    lane_pack #(.LANES(LANES)) pack_i (
        .clk       (clk),
        .rst       (rst),
        .beat_vld  (beat_vld),
        .beat_end  (beat_end),
        .beat_mask (beat_mask),
        .beat_byte (beat_byte),
        .word      (word),
        .word_vld  (out_vld)
    );

    lane_lp_watch #(.LANES(LANES)) lp_i (
        .clk      (clk),
        .rst      (rst),
        .act      (act),
        .lane_lp  (lane_lp),
        .lp_idle  (lp_idle),
        .lp_entry (lp_entry)
    );

    assign out_data = word.data;
    assign out_be   = word.be;
    assign out_last = word.last;

    // R8
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !align_idle |=> $stable(act_q));

endmodule

// File: tb/lane_merge_top_tb_top.sv
module lane_merge_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int LANES      = 4;

    typedef struct {
        bit          is_err;
        logic [31:0] data;
        logic [3:0]  be;
        logic        last;
        string       tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [1:0]        cfg_lanes = 2'd3;
    logic [LANES*8-1:0] lane_byte = '0;
    logic [LANES-1:0]  lane_vld = '0;
    logic [LANES-1:0]  lane_sot = '0;
    logic [LANES-1:0]  lane_lp = '0;
    logic              out_vld;
    logic [31:0]       out_data;
    logic [3:0]        out_be;
    logic              out_last;
    logic              lane_err;
    logic              lp_idle;
    logic              lp_entry;

    int   total = 0;
    int   bad   = 0;
    bit   done  = 0;
    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    lane_merge_top #(.LANES(LANES), .SKEW(2)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .cfg_lanes (cfg_lanes),
        .lane_byte (lane_byte),
        .lane_vld  (lane_vld),
        .lane_sot  (lane_sot),
        .lane_lp   (lane_lp),
        .out_vld   (out_vld),
        .out_data  (out_data),
        .out_be    (out_be),
        .out_last  (out_last),
        .lane_err  (lane_err),
        .lp_idle   (lp_idle),
        .lp_entry  (lp_entry)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act_v, input logic [63:0] exp_v);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act_v, exp_v);
        end
    endtask

    // monitor: pops expected items as the design produces results
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && out_vld) begin
                if (exp_q.size() == 0 || exp_q[0].is_err) begin
                    check(1'b0, "R2", "unexpected word", {27'd0, out_last, out_be, out_data}, 64'd0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check({out_data, out_be, out_last} == {e.data, e.be, e.last}, e.tag,
                          "word {data,be,last}", {27'd0, out_data, out_be, out_last},
                          {27'd0, e.data, e.be, e.last});
                end
            end
            if (!rst && lane_err) begin
                if (exp_q.size() == 0 || !exp_q[0].is_err) begin
                    check(1'b0, "R5", "unexpected lane_err", 64'd1, 64'd0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(1'b1, e.tag, "lane_err", 64'd1, 64'd1);
                end
            end
        end
    end

    // driver: queues expected items, then plays the burst onto the lanes
    task automatic burst(input int n, input int len, input logic [7:0] seed,
                         input int o0, input int o1, input int o2, input int o3,
                         input bit junk, input bit expect_err, input int new_cfg,
                         input string tag);
        int   off [4];
        int   cnt [4];
        int   tend;
        exp_t it;
        off[0] = o0; off[1] = o1; off[2] = o2; off[3] = o3;
        tend = 0;
        for (int i = 0; i < 4; i++) begin
            cnt[i] = 0;
            for (int k = 0; k < len; k++) if (k % n == i) cnt[i]++;
            if (i < n && off[i] + cnt[i] > tend) tend = off[i] + cnt[i];
        end
        if (expect_err) begin
            it = '{is_err: 1'b1, data: '0, be: '0, last: 1'b0, tag: tag};
            exp_q.push_back(it);
        end else begin
            for (int w = 0; w < len / 4; w++) begin
                it = '{is_err: 1'b0, data: '0, be: 4'hF, last: 1'b0, tag: tag};
                for (int b = 0; b < 4; b++) it.data[8*b +: 8] = seed + 8'(4*w + b);
                exp_q.push_back(it);
            end
            it = '{is_err: 1'b0, data: '0, be: '0, last: 1'b1, tag: tag};
            for (int b = 0; b < len % 4; b++) begin
                it.data[8*b +: 8] = seed + 8'(4*(len/4) + b);
                it.be[b] = 1'b1;
            end
            exp_q.push_back(it);
        end
        for (int t = 0; t < tend; t++) begin
            @(negedge clk);
            lane_vld  = '0;
            lane_sot  = '0;
            lane_byte = '0;
            for (int i = 0; i < 4; i++) begin
                if (i < n) begin
                    if (t >= off[i] && t < off[i] + cnt[i]) begin
                        lane_vld[i] = 1'b1;
                        lane_sot[i] = (t == off[i]);
                        lane_byte[8*i +: 8] = seed + 8'(i + n*(t - off[i]));
                    end
                end else if (junk) begin
                    lane_vld[i] = 1'b1;
                    lane_sot[i] = (t == 0);
                    lane_byte[8*i +: 8] = 8'hA5 ^ 8'(t);
                end
            end
            if (new_cfg >= 0 && t == 1) cfg_lanes = 2'(new_cfg);
        end
        @(negedge clk);
        lane_vld  = '0;
        lane_sot  = '0;
        lane_byte = '0;
        repeat (10) @(negedge clk);
    endtask

    task automatic set_cfg(input int n);
        @(negedge clk);
        cfg_lanes = 2'(n - 1);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R10 watchdog expired: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check(out_vld == 1'b0, "R10", "out_vld after reset", 64'(out_vld), 64'd0);
        check(lane_err == 1'b0, "R10", "lane_err after reset", 64'(lane_err), 64'd0);
        check(lp_entry == 1'b0, "R10", "lp_entry after reset", 64'(lp_entry), 64'd0);

        // R1/R2: four lanes, aligned, terminator with no leftovers
        set_cfg(4);
        burst(4, 8, 8'h10, 0, 0, 0, 0, 0, 0, -1, "R2");
        // R4: skewed start within the window, two leftover bytes
        burst(4, 10, 8'h40, 0, 1, 2, 0, 0, 0, -1, "R4");
        // R5: lane 1 three cycles late, burst dropped
        burst(4, 12, 8'h70, 0, 3, 0, 0, 0, 1, -1, "R5");
        // R6: good burst after a drop, three leftover bytes
        burst(4, 11, 8'h90, 0, 0, 1, 2, 0, 0, -1, "R6");

        // R3: one lane
        set_cfg(1);
        burst(1, 5, 8'h20, 0, 0, 0, 0, 0, 0, -1, "R3");
        // R7: two lanes with noise on lanes 2 and 3
        set_cfg(2);
        burst(2, 6, 8'h30, 0, 1, 0, 0, 1, 0, -1, "R7");
        // R3: three lanes, carry across words
        set_cfg(3);
        burst(3, 7, 8'h50, 0, 0, 0, 0, 0, 0, -1, "R3");
        burst(3, 12, 8'h60, 2, 0, 1, 0, 1, 0, -1, "R3");

        // R8: change to three lanes mid-burst, applies to the next burst only
        set_cfg(2);
        burst(2, 8, 8'hB0, 0, 0, 0, 0, 0, 0, 2, "R8");
        burst(3, 9, 8'hC0, 0, 0, 0, 0, 0, 0, -1, "R8");

        // R9/R7: low-power detection over two active lanes
        set_cfg(2);
        lane_lp = 4'b1100;
        @(negedge clk);
        @(negedge clk);
        check(lp_idle == 1'b0, "R7", "lp_idle with only idle lanes in LP", 64'(lp_idle), 64'd0);
        lane_lp = 4'b0011;
        @(negedge clk);
        check(lp_idle == 1'b1, "R9", "lp_idle on entry", 64'(lp_idle), 64'd1);
        check(lp_entry == 1'b1, "R9", "lp_entry pulse", 64'(lp_entry), 64'd1);
        @(negedge clk);
        check(lp_entry == 1'b0, "R9", "lp_entry one cycle", 64'(lp_entry), 64'd0);
        lane_lp = 4'b1011;
        @(negedge clk);
        lane_lp = 4'b0011;
        @(negedge clk);
        check(lp_entry == 1'b0, "R7", "unused lane LP toggle", 64'(lp_entry), 64'd0);
        check(lp_idle == 1'b1, "R7", "lp_idle held", 64'(lp_idle), 64'd1);
        lane_lp = 4'b0010;
        @(negedge clk);
        check(lp_idle == 1'b0, "R9", "lp_idle exit", 64'(lp_idle), 64'd0);

        repeat (20) @(negedge clk);
        check(exp_q.size() == 0, "R6", "pending expected items", 64'(exp_q.size()), 64'd0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule